// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block sets the two offsets that a FIFO's almost-empty and almost-full comparators use. While the full reset is held, a 3-bit select input chooses how the offsets are obtained. Five codes give a fixed offset that applies to both thresholds. One code loads the offsets from the low bits of the write-port data bus, and one shifts them in one bit at a time from a serial input. A parity-interleave option is captured during the same full reset. When it is set, data bit 8 is skipped in parallel loading and the higher bits move down one place to fill the gap.

A partial reset is used to flush the FIFO. It keeps the loading method, the parity option, any offsets already loaded and the done flag. Writes go to the FIFO only after the offsets are complete. Until then, enabled writes are used to load the offsets. The FIFO storage and the comparators are outside this block.

Top module: `fifo_offset_loader`

## Requirements
- R1: While `rst` is high, `fsel` codes 0, 1, 2, 3 and 4 set both `ae_ofs` and `af_ofs` to 8, 16, 64, 256 and 1024. Code 7 behaves like code 0. `cfg_done` is high from the first clock edge that samples `rst` high.
- R2: While `rst` is high, code 5 (serial) and code 6 (parallel) clear both offsets to 0 and clear `cfg_done`.
- R3: In parallel mode with the parity option clear, the first enabled write after reset loads `ae_ofs` from `wr_data[11:0]`. The second loads `af_ofs` the same way and sets `cfg_done`. Bit 12 is not used.
- R4: In parallel mode with the parity option set, each offset is `{wr_data[12:9], wr_data[7:0]}` and `wr_data[8]` has no effect.
- R5: In serial mode, each enabled write cycle shifts in one `ser_in` bit. The 12 bits of `ae_ofs` come first, then the 12 bits of `af_ofs`, each most significant bit first. `cfg_done` rises on the 24th bit. `ser_in` is ignored in cycles where `wr_en` is low.
- R6: `fifo_wr` equals `wr_en` when `cfg_done` is high and neither reset is active. Otherwise it is low, so writes that load offsets never reach the FIFO.
- R7: Once `cfg_done` is high, enabled writes do not change either offset.
- R8: A partial reset (`prst` high, `rst` low) keeps the loading method, the parity option, both offsets and `cfg_done`. It restarts an unfinished load from its first word or bit.
- R9: `fsel` and `par_sel` are sampled only while `rst` is high. Changing them afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-port clock |
| rst | input | 1 | Full reset, synchronous, active high; samples `fsel` and `par_sel` |
| prst | input | 1 | Partial reset, synchronous, active high |
| fsel | input | 3 | Offset source select (0-4 fixed, 5 serial, 6 parallel, 7 as 0) |
| par_sel | input | 1 | Parity-interleave option, sampled during full reset |
| wr_en | input | 1 | Write enable of the FIFO write port |
| wr_data | input | OFS_W+1 | Low bits of the write data bus |
| ser_in | input | 1 | Serial offset bit |
| ae_ofs | output | OFS_W | Almost-empty offset |
| af_ofs | output | OFS_W | Almost-full offset |
| cfg_done | output | 1 | Offsets are complete |
| fifo_wr | output | 1 | Write forwarded to FIFO storage |

## Verification
Every offset and the done flag are registered. Each is due on the first rising edge that samples the stimulus: the reset select, a load word or a serial bit. `fifo_wr` is combinational and is due in the same cycle as `wr_en`. The bench changes inputs on the falling edge and reads results on the next falling edge, half a period after the edge that updates them. It checks `fifo_wr` before that edge. Serial loading is checked one bit before completion and at completion, so an off-by-one in the bit count shows up.

// File: rtl/offset_cfg_pkg.sv
`timescale 1ns/1ps
package offset_cfg_pkg;

    typedef enum logic [1:0] {
        SRC_FIXED    = 2'd0,
        SRC_PARALLEL = 2'd1,
        SRC_SERIAL   = 2'd2
    } ofs_src_e;

    typedef struct packed {
        ofs_src_e   src;
        logic [3:0] fixed_log2;
    } sel_decode_t;

    localparam logic [2:0] SEL_SERIAL   = 3'd5;
    localparam logic [2:0] SEL_PARALLEL = 3'd6;
    localparam int         GAP_BIT      = 8;

    function automatic sel_decode_t decode_sel(input logic [2:0] code);
        sel_decode_t d;
        d.src        = SRC_FIXED;
        d.fixed_log2 = 4'd3;
        case (code)
            3'd0:         d.fixed_log2 = 4'd3;
            3'd1:         d.fixed_log2 = 4'd4;
            3'd2:         d.fixed_log2 = 4'd6;
            3'd3:         d.fixed_log2 = 4'd8;
            3'd4:         d.fixed_log2 = 4'd10;
            SEL_SERIAL:   d.src = SRC_SERIAL;
            SEL_PARALLEL: d.src = SRC_PARALLEL;
            default:      d.fixed_log2 = 4'd3;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/offset_sel_decode.sv
`timescale 1ns/1ps
module offset_sel_decode
    import offset_cfg_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input  logic [2:0]       fsel,
    output ofs_src_e         src,
    output logic [OFS_W-1:0] fixed_val
);
    sel_decode_t dec;

    always_comb begin
        dec       = decode_sel(fsel);
        src       = dec.src;
        fixed_val = (dec.src == SRC_FIXED) ? (OFS_W'(1) << dec.fixed_log2) : '0;
    end
endmodule

// File: rtl/offset_field_extract.sv
`timescale 1ns/1ps
module offset_field_extract
    import offset_cfg_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input  logic [OFS_W:0]   word,
    input  logic             gap_en,
    output logic [OFS_W-1:0] field
);
    localparam int HI_W = OFS_W - GAP_BIT;

    logic [OFS_W-1:0] plain;
    logic [OFS_W-1:0] gapped;

    generate
        if (HI_W > 0) begin : g_gap
            assign gapped = {word[OFS_W:GAP_BIT+1], word[GAP_BIT-1:0]};
        end else begin : g_nogap
            assign gapped = word[OFS_W-1:0];
        end
    endgenerate

    assign plain = word[OFS_W-1:0];
    assign field = gap_en ? gapped : plain;
endmodule

// File: rtl/offset_load_seq.sv
`timescale 1ns/1ps
module offset_load_seq
    import offset_cfg_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     prst,
    input  ofs_src_e src_in,
    input  logic     par_in,
    input  logic     wr_en,
    output logic     gap_q,
    output logic     done_q,
    output logic     load_ae,
    output logic     load_af,
    output logic     shift_en
);
    localparam int         TOTAL_BITS = 2 * OFS_W;
    localparam int         CNT_W      = $clog2(TOTAL_BITS);
    localparam logic [CNT_W-1:0] SER_LAST = CNT_W'(TOTAL_BITS - 1);

    ofs_src_e         src_q;
    logic [CNT_W-1:0] cnt_q;
    logic             step;

    assign step     = wr_en && !done_q && !rst && !prst;
    assign load_ae  = step && (src_q == SRC_PARALLEL) && (cnt_q == '0);
    assign load_af  = step && (src_q == SRC_PARALLEL) && (cnt_q != '0);
    assign shift_en = step && (src_q == SRC_SERIAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= src_in;
            gap_q  <= par_in;
            cnt_q  <= '0;
            done_q <= (src_in == SRC_FIXED);
        end else if (prst) begin
            if (!done_q) cnt_q <= '0;
        end else if (load_ae) begin
            cnt_q <= CNT_W'(1);
        end else if (load_af) begin
            done_q <= 1'b1;
        end else if (shift_en) begin
            if (cnt_q == SER_LAST) done_q <= 1'b1;
            else                   cnt_q  <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/fifo_offset_loader.sv
`timescale 1ns/1ps
module fifo_offset_loader
    import offset_cfg_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prst,
    input  logic [2:0]       fsel,
    input  logic             par_sel,
    input  logic             wr_en,
    input  logic [OFS_W:0]   wr_data,
    input  logic             ser_in,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs,
    output logic             cfg_done,
    output logic             fifo_wr
);
    ofs_src_e         src;
    logic [OFS_W-1:0] fixed_val;
    logic [OFS_W-1:0] field;
    logic             gap_q, load_ae, load_af, shift_en;

    offset_sel_decode #(.OFS_W(OFS_W)) u_dec (
        .fsel(fsel), .src(src), .fixed_val(fixed_val)
    );

    offset_field_extract #(.OFS_W(OFS_W)) u_ext (
        .word(wr_data), .gap_en(gap_q), .field(field)
    );

    offset_load_seq #(.OFS_W(OFS_W)) u_seq (
        .clk(clk), .rst(rst), .prst(prst), .src_in(src), .par_in(par_sel),
        .wr_en(wr_en), .gap_q(gap_q), .done_q(cfg_done),
        .load_ae(load_ae), .load_af(load_af), .shift_en(shift_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ae_ofs <= fixed_val;
            af_ofs <= fixed_val;
        end else if (load_ae) begin
            ae_ofs <= field;
        end else if (load_af) begin
            af_ofs <= field;
        end else if (shift_en) begin
            {ae_ofs, af_ofs} <= {ae_ofs[OFS_W-2:0], af_ofs, ser_in};
        end
    end

    assign fifo_wr = wr_en && cfg_done && !rst && !prst;
endmodule

// File: rtl/offset_loader_checker.sv
`timescale 1ns/1ps
module offset_loader_checker #(
    parameter int OFS_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             prst,
    input logic             wr_en,
    input logic [OFS_W-1:0] ae_ofs,
    input logic [OFS_W-1:0] af_ofs,
    input logic             cfg_done,
    input logic             fifo_wr
);
    assert_fwd_only_done_R6: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> (cfg_done && wr_en));

    assert_frozen_after_done_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> ($stable(ae_ofs) && $stable(af_ofs)));

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> cfg_done);

    assert_done_needs_write_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(cfg_done) && !$past(rst)) |-> $past(wr_en));

    assert_partial_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        prst |=> ($stable(ae_ofs) && $stable(af_ofs) && $stable(cfg_done)));
endmodule

bind fifo_offset_loader offset_loader_checker #(.OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst(rst), .prst(prst), .wr_en(wr_en), .ae_ofs(ae_ofs),
    .af_ofs(af_ofs), .cfg_done(cfg_done), .fifo_wr(fifo_wr)
);

// File: tb/fifo_offset_loader_test.sv
`timescale 1ns/1ps
module fifo_offset_loader_test;
    localparam int OFS_W = 12;

    logic             clk = 1'b0;
    logic             rst, prst, par_sel, wr_en, ser_in;
    logic [2:0]       fsel;
    logic [OFS_W:0]   wr_data;
    logic [OFS_W-1:0] ae_ofs, af_ofs;
    logic             cfg_done, fifo_wr;
    int               n_chk = 0;
    int               n_fail = 0;

    always #2.5 clk = ~clk;

    fifo_offset_loader #(.OFS_W(OFS_W)) uut (
        .clk(clk), .rst(rst), .prst(prst), .fsel(fsel), .par_sel(par_sel),
        .wr_en(wr_en), .wr_data(wr_data), .ser_in(ser_in), .ae_ofs(ae_ofs),
        .af_ofs(af_ofs), .cfg_done(cfg_done), .fifo_wr(fifo_wr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [2:0] code, input logic par);
        rst = 1'b1; prst = 1'b0; wr_en = 1'b0; fsel = code; par_sel = par;
        step();
        rst = 1'b0;
    endtask

    task automatic pwrite(input logic [OFS_W:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic t_fixed();
        logic [OFS_W-1:0] exp_v [8];
        exp_v = '{12'd8, 12'd16, 12'd64, 12'd256, 12'd1024, 12'd0, 12'd0, 12'd8};
        for (int c = 0; c < 8; c++) begin
            if (c == 5 || c == 6) continue;
            do_reset(3'(c), 1'b0);
            chk("R1 fixed ae", 32'(ae_ofs), 32'(exp_v[c]));
            chk("R1 fixed af", 32'(af_ofs), 32'(exp_v[c]));
            chk("R1 fixed done", 32'(cfg_done), 32'd1);
        end
        fsel = 3'd6;
        wr_en = 1'b1; wr_data = 13'h0ABC;
        #1;
        chk("R6 write forwarded", 32'(fifo_wr), 32'd1);
        step();
        wr_en = 1'b0;
        chk("R7 ae unchanged", 32'(ae_ofs), 32'd8);
        chk("R9 fsel ignored af", 32'(af_ofs), 32'd8);
    endtask

    task automatic t_parallel();
        do_reset(3'd6, 1'b0);
        chk("R2 parallel ae cleared", 32'(ae_ofs), 32'd0);
        chk("R2 parallel not done", 32'(cfg_done), 32'd0);
        par_sel = 1'b1;
        wr_en = 1'b1; wr_data = 13'h11A5;
        #1;
        chk("R6 load write blocked", 32'(fifo_wr), 32'd0);
        step();
        chk("R3 ae loaded bit8 kept R9", 32'(ae_ofs), 32'h1A5);
        chk("R3 not done after one", 32'(cfg_done), 32'd0);
        pwrite(13'h0ABC);
        chk("R3 af loaded", 32'(af_ofs), 32'hABC);
        chk("R3 done", 32'(cfg_done), 32'd1);
        pwrite(13'h0777);
        chk("R7 ae frozen", 32'(ae_ofs), 32'h1A5);
        chk("R7 af frozen", 32'(af_ofs), 32'hABC);
    endtask

    task automatic t_parity();
        do_reset(3'd6, 1'b1);
        par_sel = 1'b0;
        pwrite(13'h1F3C);
        pwrite(13'h0A55);
        chk("R4 ae gapped", 32'(ae_ofs), 32'hF3C);
        chk("R4 af gapped", 32'(af_ofs), 32'h555);
        do_reset(3'd6, 1'b1);
        pwrite(13'h1E3C);
        chk("R4 bit8 ignored", 32'(ae_ofs), 32'hF3C);
    endtask

    task automatic t_serial();
        logic [2*OFS_W-1:0] pat;
        pat = {12'hA5C, 12'h3E1};
        do_reset(3'd5, 1'b0);
        chk("R2 serial not done", 32'(cfg_done), 32'd0);
        for (int i = 2*OFS_W-1; i >= 0; i--) begin
            if (i == 10) begin
                wr_en = 1'b0; ser_in = ~pat[i];
                step();
            end
            wr_en = 1'b1; ser_in = pat[i]; wr_data = 13'h1FFF;
            step();
            if (i == 1) chk("R5 not done before last bit", 32'(cfg_done), 32'd0);
        end
        wr_en = 1'b0;
        chk("R5 serial done", 32'(cfg_done), 32'd1);
        chk("R5 serial ae", 32'(ae_ofs), 32'hA5C);
        chk("R5 serial af", 32'(af_ofs), 32'h3E1);
    endtask

    task automatic t_partial();
        do_reset(3'd6, 1'b0);
        pwrite(13'h0111);
        prst = 1'b1; wr_en = 1'b1; wr_data = 13'h0999;
        #1;
        chk("R6 partial blocks write", 32'(fifo_wr), 32'd0);
        step();
        prst = 1'b0; wr_en = 1'b0;
        chk("R8 ae kept", 32'(ae_ofs), 32'h111);
        chk("R8 still loading", 32'(cfg_done), 32'd0);
        pwrite(13'h0222);
        chk("R8 restart loads ae", 32'(ae_ofs), 32'h222);
        chk("R8 restart af pending", 32'(cfg_done), 32'd0);
        pwrite(13'h0333);
        chk("R8 af after restart", 32'(af_ofs), 32'h333);
        prst = 1'b1;
        step();
        prst = 1'b0;
        chk("R8 done kept", 32'(cfg_done), 32'd1);
        chk("R8 af kept", 32'(af_ofs), 32'h333);
        do_reset(3'd3, 1'b0);
        prst = 1'b1;
        step();
        prst = 1'b0;
        chk("R8 fixed kept", 32'(ae_ofs), 32'd256);
    endtask

    initial begin
        rst = 1'b1; prst = 1'b0; fsel = 3'd0; par_sel = 1'b0;
        wr_en = 1'b0; wr_data = '0; ser_in = 1'b0;
        @(negedge clk);
        t_fixed();
        t_parallel();
        t_parity();
        t_serial();
        t_partial();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule